// File: doc/BRIEF.md
# Serial Channel with Status and Control Registers

The block is one asynchronous serial channel that a processor drives through four word registers: a data register, a status register, a control register and a baud scaler. A byte written to the data register lands in a one-byte holding stage, then moves into a shift stage that sends it on `txd_o` as a frame. The frame has one low start bit, eight data bits sent least significant bit first, an optional parity bit and one high stop bit. The receiver samples `rxd_i` near the middle of each bit. It places a good byte in the data register and raises data-ready. Overrun, parity, framing and break conditions each set their own sticky flag.

The control register selects the options. It turns the receiver and transmitter on or off, enables parity and picks odd or even parity, and enables hardware flow control on `cts_i`/`rts_o`. It also enables loopback, in which the serial output feeds the receiver internally, and holds two interrupt enables. `irq_o` gives a one-cycle pulse when a byte is accepted with the receive interrupt enabled. It also pulses when the holding stage hands its byte to the shift stage with the transmit interrupt enabled.

The register word index is `addr_i`: 0 data, 1 status, 2 control, 3 scaler. Reads are combinational on `rdata_o`. Side effects of `rd_i` and `wr_i` take place at the rising clock edge.

Top module: `uart_chan`

## Requirements
- R1: After reset, status reads 0x06, control reads 0, `txd_o` and `rts_o` are high and `irq_o` is low.
- R2: The baud tick period is (scaler+1) clocks and every bit lasts 8 ticks. A transmitted frame is a low start bit, 8 data bits LSB first, an optional parity bit and a high stop bit.
- R3: Control bit 5 enables parity. Control bit 4 selects the parity kind: 1 makes the count of ones in data plus parity odd, 0 makes it even.
- R4: Status bit 2 is set while the holding stage is empty, and bit 1 is set while the shift stage is idle. A data write while the holding stage is full is dropped.
- R5: With flow control enabled (control bit 6), no frame starts while `cts_i` is low. `rts_o` is low while the receiver is disabled or data-ready is set. `rts_o` is high whenever flow control is off.
- R6: A received byte sets data-ready (status bit 0) and appears in bits 7:0 of the data register. A read of the data register clears data-ready.
- R7: A byte that completes while data-ready is set sets overrun (status bit 4) and is dropped. The byte already held is kept.
- R8: A wrong parity bit sets status bit 5 and the byte is still delivered. A low stop bit sets status bit 6. A frame whose data, parity and stop bits are all low sets break (status bit 3) instead and delivers no byte. After a low stop bit the receiver waits for the line to go high before it looks for a new start bit. Any write to the status register clears bits 3 to 6.
- R9: With loopback (control bit 7), the transmitted frame reaches the receiver, `txd_o` stays high and `rxd_i` is ignored.
- R10: `irq_o` pulses for one cycle on byte acceptance when control bit 2 is set, and on the hand-off from holding to shift stage when control bit 3 is set.
- R11: With control bit 0 clear, incoming frames are ignored. With control bit 1 clear, a held byte is not sent until the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register word index |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register |
| rxd_i | input | 1 | Serial input |
| cts_i | input | 1 | Peer ready to receive, active high |
| txd_o | output | 1 | Serial output, idles high |
| rts_o | output | 1 | Ready to receive, active high |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The bench blocks the transmitter with `cts_i` low and writes twice. A design that overwrote the holding stage would send the second byte, and one that ignored flow control would send at once. Back-to-back frames without a read check that overrun keeps the first byte rather than the newer one. A frame with a low stop bit is held low past mid-stop to catch a receiver that re-arms on the still-low line and invents a byte. An all-zero frame must raise break without data-ready. In loopback `rxd_i` is held low to show that a receiver still fed from the pin would read garbage.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    REG_DATA  = 2'd0,
    REG_STAT  = 2'd1,
    REG_CTRL  = 2'd2,
    REG_SCALE = 2'd3
  } reg_sel_e;

  // packed MSB first: bit 7 loop_en .. bit 0 rx_en
  typedef struct packed {
    logic loop_en;
    logic flow_en;
    logic par_en;
    logic par_odd;
    logic tx_ie;
    logic rx_ie;
    logic tx_en;
    logic rx_en;
  } ctrl_t;
endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int SCALE_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               tick_o
);
  logic [SCALE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q  <= scale_i;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              flow_en_i,
  input  logic              cts_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              line_o,
  output logic              thr_empty_o,
  output logic              tsr_empty_o,
  output logic              load_o
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0]  thr_q;
  logic               full_q, busy_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;
  logic [2:0]         sub_q;
  logic               par_bit, start;

  assign par_bit = par_odd_i ? ~(^thr_q) : (^thr_q);
  assign start   = tick_i & ~busy_q & full_q & en_i & (~flow_en_i | cts_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q  <= '0;
      full_q <= 1'b0;
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      sub_q  <= '0;
      load_o <= 1'b0;
    end else begin
      load_o <= 1'b0;
      if (wr_i && !full_q) begin
        thr_q  <= wdata_i;
        full_q <= 1'b1;
      end
      if (start) begin
        sh_q   <= par_en_i ? {1'b1, par_bit, thr_q, 1'b0} : {2'b11, thr_q, 1'b0};
        left_q <= par_en_i ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
        sub_q  <= '0;
        busy_q <= 1'b1;
        full_q <= 1'b0;
        load_o <= 1'b1;
      end else if (busy_q && tick_i) begin
        sub_q <= sub_q + 1'b1;
        if (sub_q == 3'd7) begin
          sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
          left_q <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) busy_q <= 1'b0;
        end
      end
    end
  end

  assign line_o      = busy_q ? sh_q[0] : 1'b1;
  assign thr_empty_o = ~full_q;
  assign tsr_empty_o = ~busy_q;

  // R5
  cts_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(!flow_en_i || cts_i));
  // R4
  hold_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_q) |=> $stable(thr_q));
endmodule

// File: rtl/uart_rx.sv
module uart_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              line_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              brk_o
);
  localparam int IDX_W = $clog2(DATA_W + 3);

  logic              run_q, hold_q, pbit_q;
  logic [2:0]        sub_q;
  logic [IDX_W-1:0]  idx_q, last_idx;
  logic [DATA_W-1:0] sh_q;
  logic              exp_par, brk_cond;

  assign last_idx = par_en_i ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);
  assign exp_par  = par_odd_i ? ~(^sh_q) : (^sh_q);
  assign brk_cond = ~line_i & (sh_q == '0) & (~par_en_i | ~pbit_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      hold_q <= 1'b0;
      pbit_q <= 1'b0;
      sub_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      done_o <= 1'b0;
      data_o <= '0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
      brk_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        run_q  <= 1'b0;
        hold_q <= 1'b0;
      end else if (tick_i) begin
        if (!run_q) begin
          if (hold_q) begin
            if (line_i) hold_q <= 1'b0;
          end else if (!line_i) begin
            run_q <= 1'b1;
            sub_q <= '0;
            idx_q <= '0;
          end
        end else begin
          sub_q <= sub_q + 1'b1;
          if (sub_q == 3'd3) begin       // mid-bit
            idx_q <= idx_q + 1'b1;
            if (idx_q == '0) begin
              if (line_i) run_q <= 1'b0;  // false start
            end else if (idx_q <= IDX_W'(DATA_W)) begin
              sh_q <= {line_i, sh_q[DATA_W-1:1]};
            end else if (idx_q == last_idx) begin
              run_q  <= 1'b0;
              hold_q <= ~line_i;
              done_o <= 1'b1;
              data_o <= sh_q;
              perr_o <= par_en_i & (pbit_q ^ exp_par);
              brk_o  <= brk_cond;
              ferr_o <= ~line_i & ~brk_cond;
            end else begin
              pbit_q <= line_i;
            end
          end
        end
      end
    end
  end

  // R6
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(run_q));
  // R8
  brk_ferr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(brk_o && ferr_o));
endmodule

// File: rtl/uart_chan.sv
module uart_chan
  import uart_chan_pkg::*;
#(
  parameter int SCALE_W = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        rxd_i,
  input  logic        cts_i,
  output logic        txd_o,
  output logic        rts_o,
  output logic        irq_o
);
  ctrl_t              ctrl_q;
  logic [SCALE_W-1:0] scale_q;
  logic [DATA_W-1:0]  rbr_q, rx_data;
  logic               dr_q, ovr_q, perr_q, ferr_q, brk_q;
  logic [1:0]         rxd_sync_q;
  logic               tick, tx_line, rx_line, thr_empty, tsr_empty, tx_load;
  logic               rx_done, rx_perr, rx_ferr, rx_brk;
  logic               rd_clr, stat_wr, rx_accept;

  assign rd_clr    = rd_i && (addr_i == REG_DATA);
  assign stat_wr   = wr_i && (addr_i == REG_STAT);
  assign rx_accept = rx_done & ~rx_brk & ~(dr_q & ~rd_clr);
  assign rx_line   = ctrl_q.loop_en ? tx_line : rxd_sync_q[1];

  uart_baud #(.SCALE_W(SCALE_W)) u_baud (
    .clk_i, .rst_ni, .scale_i(scale_q), .tick_o(tick)
  );

  uart_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni, .tick_i(tick), .en_i(ctrl_q.tx_en),
    .par_en_i(ctrl_q.par_en), .par_odd_i(ctrl_q.par_odd),
    .flow_en_i(ctrl_q.flow_en), .cts_i,
    .wr_i(wr_i && (addr_i == REG_DATA)), .wdata_i(wdata_i[DATA_W-1:0]),
    .line_o(tx_line), .thr_empty_o(thr_empty), .tsr_empty_o(tsr_empty),
    .load_o(tx_load)
  );

  uart_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .en_i(ctrl_q.rx_en), .line_i(rx_line),
    .par_en_i(ctrl_q.par_en), .par_odd_i(ctrl_q.par_odd),
    .done_o(rx_done), .data_o(rx_data), .perr_o(rx_perr),
    .ferr_o(rx_ferr), .brk_o(rx_brk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      scale_q    <= '0;
      rbr_q      <= '0;
      dr_q       <= 1'b0;
      ovr_q      <= 1'b0;
      perr_q     <= 1'b0;
      ferr_q     <= 1'b0;
      brk_q      <= 1'b0;
      rxd_sync_q <= 2'b11;
      irq_o      <= 1'b0;
    end else begin
      rxd_sync_q <= {rxd_sync_q[0], rxd_i};
      if (wr_i && addr_i == REG_CTRL)  ctrl_q  <= ctrl_t'(wdata_i[7:0]);
      if (wr_i && addr_i == REG_SCALE) scale_q <= wdata_i[SCALE_W-1:0];
      if (rd_clr) dr_q <= 1'b0;
      if (stat_wr) begin
        ovr_q  <= 1'b0;
        perr_q <= 1'b0;
        ferr_q <= 1'b0;
        brk_q  <= 1'b0;
      end
      // error set wins over a same-cycle clear
      if (rx_done) begin
        if (rx_brk) brk_q <= 1'b1;
        else if (!rx_accept) ovr_q <= 1'b1;
        else begin
          rbr_q <= rx_data;
          dr_q  <= 1'b1;
          if (rx_perr) perr_q <= 1'b1;
          if (rx_ferr) ferr_q <= 1'b1;
        end
      end
      irq_o <= (rx_accept & ctrl_q.rx_ie) | (tx_load & ctrl_q.tx_ie);
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_sel_e'(addr_i))
      REG_DATA:  rdata_o[DATA_W-1:0]  = rbr_q;
      REG_STAT:  rdata_o[6:0]         = {ferr_q, perr_q, ovr_q, brk_q, thr_empty, tsr_empty, dr_q};
      REG_CTRL:  rdata_o[7:0]         = ctrl_q;
      REG_SCALE: rdata_o[SCALE_W-1:0] = scale_q;
      default:   rdata_o = '0;
    endcase
  end

  assign txd_o = ctrl_q.loop_en | tx_line;
  assign rts_o = ~ctrl_q.flow_en | (ctrl_q.rx_en & ~dr_q);

  // R7
  ovr_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(dr_q));
  // R10
  irq_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ctrl_q.rx_ie || ctrl_q.tx_ie));
  // R10
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R8
  brk_nodata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_q) |-> !$rose(dr_q));
endmodule

// File: tb/uart_chan_bench.sv
module uart_chan_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int BIT_CLK = 16;  // scaler 1 -> 2 clocks/tick, 8 ticks/bit

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  addr_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rxd_i = 1'b1, cts_i = 1'b1;
  logic        txd_o, rts_o, irq_o;

  int total = 0, bad = 0;
  int irq_cnt = 0, tx_low_cnt = 0, mon_frames = 0;
  bit mon_par_en = 0, mon_par_odd = 0;
  logic [7:0] exp_q[$];

  always #2 clk_i = ~clk_i;

  uart_chan u_uart_chan (.*);

  always @(posedge clk_i) begin
    if (irq_o) irq_cnt <= irq_cnt + 1;
    if (!txd_o) tx_low_cnt <= tx_low_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  // driver for the transmit scoreboard
  task automatic send_tx(input logic [7:0] b);
    exp_q.push_back(b);
    wr(2'd0, {24'h0, b});
  endtask

  // drives one frame on rxd_i; use_par adds bit p
  task automatic send_rx(input logic [7:0] b, input bit use_par, input bit p, input bit stop);
    @(negedge clk_i);
    rxd_i = 1'b0; waitc(BIT_CLK);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i); rxd_i = b[i]; waitc(BIT_CLK);
    end
    if (use_par) begin
      @(negedge clk_i); rxd_i = p; waitc(BIT_CLK);
    end
    @(negedge clk_i); rxd_i = stop; waitc(BIT_CLK);
    @(negedge clk_i); rxd_i = 1'b1; waitc(3 * BIT_CLK);
  endtask

  // monitor: decodes txd_o and compares against the queue (R2, R3)
  initial begin
    forever begin
      logic [7:0] got, exp;
      logic st, pb, sp, ok;
      @(negedge txd_o);
      waitc(BIT_CLK / 2); #1 st = txd_o;
      for (int i = 0; i < 8; i++) begin
        waitc(BIT_CLK); #1 got[i] = txd_o;
      end
      pb = 1'b0;
      if (mon_par_en) begin
        waitc(BIT_CLK); #1 pb = txd_o;
      end
      waitc(BIT_CLK); #1 sp = txd_o;
      mon_frames++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected frame", got, 0);
      end else begin
        exp = exp_q.pop_front();
        ok = (got == exp) && !st && sp;
        if (mon_par_en) ok = ok && (pb == (mon_par_odd ? ~(^exp) : (^exp)));
        chk(ok, mon_par_en ? "R3 tx parity frame" : "R2 tx frame", got, exp);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int s0, s1;
    waitc(3);
    @(negedge clk_i) rst_ni = 1'b1;
    waitc(2);

    // R1 reset state
    rd(2'd1, d); chk(d == 32'h06, "R1 status", d, 32'h06);
    rd(2'd2, d); chk(d == 0, "R1 control", d, 0);
    chk(txd_o && rts_o && !irq_o, "R1 pins", {txd_o, rts_o, irq_o}, 3'b110);

    wr(2'd3, 32'd1);

    // R2 plain frames, R10 tx interrupt
    wr(2'd2, 32'h0A);
    s0 = irq_cnt;
    send_tx(8'hA5); waitc(220);
    send_tx(8'h00); waitc(220);
    chk(irq_cnt - s0 == 2, "R10 tx irq count", irq_cnt - s0, 2);
    chk(exp_q.size() == 0, "R2 frames sent", exp_q.size(), 0);

    // R3 parity even then odd
    wr(2'd2, 32'h22); mon_par_en = 1; mon_par_odd = 0;
    send_tx(8'h3C); waitc(240);
    send_tx(8'h01); waitc(240);
    wr(2'd2, 32'h32); mon_par_odd = 1;
    send_tx(8'h01); waitc(240);
    send_tx(8'h80); waitc(240);
    mon_par_en = 0;

    // R5 flow control, R4 hold flags and dropped write
    wr(2'd2, 32'h42); cts_i = 1'b0;
    s0 = mon_frames;
    exp_q.push_back(8'h11);
    wr(2'd0, 32'h11); wr(2'd0, 32'h22);
    waitc(200);
    chk(mon_frames == s0, "R5 cts blocks start", mon_frames - s0, 0);
    rd(2'd1, d); chk((d & 32'h06) == 32'h02, "R4 holding full shift idle", d & 6, 2);
    cts_i = 1'b1; waitc(400);
    chk(mon_frames - s0 == 1, "R4 only first byte sent", mon_frames - s0, 1);
    rd(2'd1, d); chk((d & 32'h06) == 32'h06, "R4 both empty", d & 6, 6);

    // R11 transmitter disabled holds byte
    wr(2'd2, 32'h00);
    s0 = mon_frames;
    send_tx(8'h33); waitc(220);
    chk(mon_frames == s0, "R11 tx disabled", mon_frames - s0, 0);
    wr(2'd2, 32'h02); waitc(240);
    chk(mon_frames - s0 == 1, "R11 tx enabled sends", mon_frames - s0, 1);

    // R6 receive with R10 rx interrupt
    wr(2'd2, 32'h05);
    s0 = irq_cnt;
    send_rx(8'h5A, 0, 0, 1);
    rd(2'd1, d); chk(d == 32'h07, "R6 data ready", d, 32'h07);
    rd(2'd0, d); chk(d == 32'h5A, "R6 data", d, 32'h5A);
    rd(2'd1, d); chk(d == 32'h06, "R6 read clears ready", d, 32'h06);
    chk(irq_cnt - s0 == 1, "R10 rx irq", irq_cnt - s0, 1);

    // R7 overrun keeps first byte
    send_rx(8'h11, 0, 0, 1);
    send_rx(8'h22, 0, 0, 1);
    rd(2'd1, d); chk(d == 32'h17, "R7 overrun flag", d, 32'h17);
    rd(2'd0, d); chk(d == 32'h11, "R7 first byte kept", d, 32'h11);
    wr(2'd1, 32'h0);
    rd(2'd1, d); chk(d == 32'h06, "R8 status write clears", d, 32'h06);

    // R8 parity error (even, wrong bit)
    wr(2'd2, 32'h21);
    send_rx(8'h03, 1, 1, 1);
    rd(2'd1, d); chk(d == 32'h27, "R8 parity error", d, 32'h27);
    rd(2'd0, d); chk(d == 32'h03, "R8 parity data kept", d, 32'h03);
    wr(2'd1, 32'h0);

    // R8 framing error, line held low past mid-stop
    wr(2'd2, 32'h01);
    send_rx(8'h55, 0, 0, 0);
    rd(2'd1, d); chk(d == 32'h47, "R8 framing error", d, 32'h47);
    rd(2'd0, d); chk(d == 32'h55, "R8 framing data", d, 32'h55);
    wr(2'd1, 32'h0);
    rd(2'd1, d); chk(d == 32'h06, "R8 no phantom byte", d, 32'h06);

    // R8 break
    send_rx(8'h00, 0, 0, 0);
    rd(2'd1, d); chk(d == 32'h0E, "R8 break no data", d, 32'h0E);
    wr(2'd1, 32'h0);

    // R11 receiver disabled
    wr(2'd2, 32'h00);
    send_rx(8'h77, 0, 0, 1);
    rd(2'd1, d); chk(d == 32'h06, "R11 rx disabled", d, 32'h06);
    chk(rts_o == 1'b1, "R5 rts high without flow", rts_o, 1);

    // R5 rts
    wr(2'd2, 32'h41); #1;
    chk(rts_o == 1'b1, "R5 rts ready", rts_o, 1);
    send_rx(8'h44, 0, 0, 1); #1;
    chk(rts_o == 1'b0, "R5 rts low on data ready", rts_o, 0);
    rd(2'd0, d); #1;
    chk(rts_o == 1'b1, "R5 rts after read", rts_o, 1);

    // R9 loopback, external pin held low
    wr(2'd2, 32'h83);
    rxd_i = 1'b0;
    s0 = tx_low_cnt; s1 = mon_frames;
    wr(2'd0, 32'h96); waitc(240);
    chk(tx_low_cnt == s0 && mon_frames == s1, "R9 txd idle", tx_low_cnt - s0, 0);
    rd(2'd1, d); chk(d == 32'h07, "R9 loop data ready", d, 32'h07);
    rd(2'd0, d); chk(d == 32'h96, "R9 loop data", d, 32'h96);
    wr(2'd2, 32'h00);
    rxd_i = 1'b1;
    waitc(20);

    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule